// File: doc/BRIEF.md
# Dual-Port Address Collision Arbiter

This block sits beside a two-port memory array and watches both of its access ports. Each cycle it checks whether both ports are enabled and present the same address. When they do, one port keeps the access and the other port is told to wait through an active-low busy signal. The block also removes the write enable that the waiting port would otherwise send to the array. Reads from the waiting port are not touched, because only the write strobe toward the array passes through the block.

The winner is the port whose request was already in place in the previous cycle. When both requests appear in the same cycle, the left port wins. A three-valued owner register (none, left, right) keeps the winner for as long as its request stays unchanged. Whether each access is a read or a write plays no part in the decision.

A mode input sets the role of the busy pins. In arbitrating mode the block drives them push-pull. In follower mode it stops driving them and treats the incoming levels as plain write inhibits, so several arrays can share the decision made by one arbitrating block. Each pin is modelled as separate in, out and output-enable signals.

Top module: `dp_collision_arbiter`

## Requirements
- R1: With `master_mode` = 1, if the ports are not both enabled on equal addresses, both `l_busy_n_out` and `r_busy_n_out` are 1. Busy is active low.
- R2: The decision uses only enables and addresses. Changing `l_wr` or `r_wr` never changes either busy output.
- R3: In a collision, a port whose {enable, address} is unchanged since the previous cycle wins against a port whose request changed. The loser's busy output goes to 0 in that same cycle.
- R4: In a collision where both requests changed in the same cycle, or neither did while no owner is recorded, the left port wins and `r_busy_n_out` = 0.
- R5: Once a port wins, it keeps the grant while the collision persists and its own request is unchanged. When the collision ends, the owner returns to none.
- R6: `l_busy_n_out` and `r_busy_n_out` are never 0 together.
- R7: With `master_mode` = 1, `l_we` = `l_en & l_wr & l_busy_n_out`, and the same holds for the right port. The busy input pins are ignored in this mode.
- R8: With `master_mode` = 0, both output enables are 0, both busy outputs are 1, and `x_we` = `x_en & x_wr & x_busy_n_in` for each port x.
- R9: With `master_mode` = 1, both `l_busy_oe` and `r_busy_oe` are 1.
- R10: After reset, with both ports disabled, both busy outputs are 1 and both write enables are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| master_mode | input | 1 | 1: block arbitrates and drives busy; 0: busy pins are write-inhibit inputs |
| l_en | input | 1 | Left port enable |
| l_addr | input | ADDR_W | Left port address |
| l_wr | input | 1 | Left port write request |
| l_busy_n_in | input | 1 | Level seen on the left busy pin (used in follower mode) |
| l_busy_n_out | output | 1 | Left busy drive value, active low |
| l_busy_oe | output | 1 | Left busy pin output enable |
| l_we | output | 1 | Gated left write enable toward the array |
| r_en | input | 1 | Right port enable |
| r_addr | input | ADDR_W | Right port address |
| r_wr | input | 1 | Right port write request |
| r_busy_n_in | input | 1 | Level seen on the right busy pin (used in follower mode) |
| r_busy_n_out | output | 1 | Right busy drive value, active low |
| r_busy_oe | output | 1 | Right busy pin output enable |
| r_we | output | 1 | Gated right write enable toward the array |

## Verification
The arbiter is driven with distinct addresses to show that busy stays released, and with one port parked while the other moves onto its address to show which port is treated as first. It is then driven with both ports landing on one address in the same cycle, including the all-ones address, to check the left-wins tie rule. The winner is released and re-enabled so that ownership changes sides, and the write flags are toggled during a collision to show they have no effect on busy. Follower-mode patterns with each inhibit level show that the pins change role, and a switch back to arbitrating mode with unchanged requests exercises the tie rule when no owner is recorded.

// File: rtl/dpca_pkg.sv
package dpca_pkg;

    typedef enum logic [1:0] {
        OWN_NONE  = 2'd0,
        OWN_LEFT  = 2'd1,
        OWN_RIGHT = 2'd2
    } owner_e;

    typedef struct packed {
        logic busy_n;
        logic busy_oe;
        logic we;
    } pin_out_t;

    // Resolve a collision given the recorded owner and which requests moved.
    function automatic owner_e pick_owner(input owner_e held,
                                          input logic   left_moved,
                                          input logic   right_moved);
        owner_e res;
        if (held == OWN_LEFT && !left_moved)
            res = OWN_LEFT;
        else if (held == OWN_RIGHT && !right_moved)
            res = OWN_RIGHT;
        else if (right_moved && !left_moved)
            res = OWN_LEFT;
        else if (left_moved && !right_moved)
            res = OWN_RIGHT;
        else
            res = OWN_LEFT;
        return res;
    endfunction

endpackage

// File: rtl/dpca_req_track.sv
module dpca_req_track #(
    parameter int ADDR_W = 13
) (
    input  logic              clk,
    input  logic              en,
    input  logic [ADDR_W-1:0] addr,
    output logic              moved
);
    localparam int REQ_W = ADDR_W + 1;

    logic [REQ_W-1:0] cur_req;
    logic [REQ_W-1:0] last_req;

    // A disabled port is one request value regardless of its address lines.
    assign cur_req = en ? {1'b1, addr} : '0;

    // History follows the pins through reset so "moved" is meaningful at once.
    always_ff @(posedge clk) begin
        last_req <= cur_req;
    end

    assign moved = (cur_req != last_req);
endmodule

// File: rtl/dpca_core.sv
module dpca_core
    import dpca_pkg::*;
#(
    parameter int ADDR_W = 13
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              master_mode,
    input  logic              l_en,
    input  logic [ADDR_W-1:0] l_addr,
    input  logic              l_moved,
    input  logic              r_en,
    input  logic [ADDR_W-1:0] r_addr,
    input  logic              r_moved,
    output logic              l_loses,
    output logic              r_loses
);
    owner_e owner_q;
    owner_e grant;
    logic   collide;

    assign collide = master_mode & l_en & r_en & (l_addr == r_addr);

    always_comb begin
        if (collide)
            grant = pick_owner(owner_q, l_moved, r_moved);
        else
            grant = OWN_NONE;
    end

    always_ff @(posedge clk) begin
        if (rst)
            owner_q <= OWN_NONE;
        else
            owner_q <= grant;
    end

    assign l_loses = (grant == OWN_RIGHT);
    assign r_loses = (grant == OWN_LEFT);
endmodule

// File: rtl/dpca_pin_gate.sv
module dpca_pin_gate
    import dpca_pkg::*;
(
    input  logic     master_mode,
    input  logic     loses,
    input  logic     en,
    input  logic     wr,
    input  logic     busy_n_in,
    output pin_out_t pin
);
    logic inhibit;

    // Arbitrating: own decision inhibits. Follower: external level inhibits.
    assign inhibit = master_mode ? loses : ~busy_n_in;

    always_comb begin
        pin.busy_n  = ~(master_mode & loses);
        pin.busy_oe = master_mode;
        pin.we      = en & wr & ~inhibit;
    end
endmodule

// File: rtl/dp_collision_arbiter.sv
module dp_collision_arbiter
    import dpca_pkg::*;
#(
    parameter int ADDR_W = 13
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              master_mode,
    input  logic              l_en,
    input  logic [ADDR_W-1:0] l_addr,
    input  logic              l_wr,
    input  logic              l_busy_n_in,
    output logic              l_busy_n_out,
    output logic              l_busy_oe,
    output logic              l_we,
    input  logic              r_en,
    input  logic [ADDR_W-1:0] r_addr,
    input  logic              r_wr,
    input  logic              r_busy_n_in,
    output logic              r_busy_n_out,
    output logic              r_busy_oe,
    output logic              r_we
);
    localparam int NPORT = 2;

    logic              en_v    [NPORT];
    logic [ADDR_W-1:0] addr_v  [NPORT];
    logic              wr_v    [NPORT];
    logic              bin_v   [NPORT];
    logic              moved_v [NPORT];
    logic              lose_v  [NPORT];
    pin_out_t          pin_v   [NPORT];

    assign en_v[0]   = l_en;
    assign en_v[1]   = r_en;
    assign addr_v[0] = l_addr;
    assign addr_v[1] = r_addr;
    assign wr_v[0]   = l_wr;
    assign wr_v[1]   = r_wr;
    assign bin_v[0]  = l_busy_n_in;
    assign bin_v[1]  = r_busy_n_in;

    for (genvar p = 0; p < NPORT; p++) begin : g_port
        dpca_req_track #(.ADDR_W(ADDR_W)) u_track (
            .clk   (clk),
            .en    (en_v[p]),
            .addr  (addr_v[p]),
            .moved (moved_v[p])
        );

        dpca_pin_gate u_gate (
            .master_mode (master_mode),
            .loses       (lose_v[p]),
            .en          (en_v[p]),
            .wr          (wr_v[p]),
            .busy_n_in   (bin_v[p]),
            .pin         (pin_v[p])
        );
    end

    dpca_core #(.ADDR_W(ADDR_W)) u_core (
        .clk         (clk),
        .rst         (rst),
        .master_mode (master_mode),
        .l_en        (l_en),
        .l_addr      (l_addr),
        .l_moved     (moved_v[0]),
        .r_en        (r_en),
        .r_addr      (r_addr),
        .r_moved     (moved_v[1]),
        .l_loses     (lose_v[0]),
        .r_loses     (lose_v[1])
    );

    assign l_busy_n_out = pin_v[0].busy_n;
    assign l_busy_oe    = pin_v[0].busy_oe;
    assign l_we         = pin_v[0].we;
    assign r_busy_n_out = pin_v[1].busy_n;
    assign r_busy_oe    = pin_v[1].busy_oe;
    assign r_we         = pin_v[1].we;
endmodule

// File: rtl/dp_collision_arbiter_chk.sv
module dp_collision_arbiter_chk #(
    parameter int ADDR_W = 13
) (
    input logic              clk,
    input logic              rst,
    input logic              master_mode,
    input logic              l_en,
    input logic [ADDR_W-1:0] l_addr,
    input logic              l_wr,
    input logic              l_busy_n_out,
    input logic              l_busy_oe,
    input logic              l_we,
    input logic              r_en,
    input logic [ADDR_W-1:0] r_addr,
    input logic              r_wr,
    input logic              r_busy_n_out,
    input logic              r_busy_oe,
    input logic              r_we
);
    logic same_tgt;
    assign same_tgt = l_en && r_en && (l_addr == r_addr);

    // R1
    no_busy_apart_chk: assert property (@(posedge clk) disable iff (rst)
        (master_mode && !same_tgt) |-> (l_busy_n_out && r_busy_n_out));

    // R3
    first_arrival_chk: assert property (@(posedge clk) disable iff (rst)
        (master_mode && same_tgt && !$past(same_tgt) && $stable(l_en) && $stable(l_addr))
        |-> !r_busy_n_out);

    // R5
    grant_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (master_mode && same_tgt && !r_busy_n_out)
        |=> (!(master_mode && same_tgt && $stable(l_addr) && $stable(l_en)) || !r_busy_n_out));

    // R6
    never_both_busy_chk: assert property (@(posedge clk) disable iff (rst)
        !(!l_busy_n_out && !r_busy_n_out));

    // R7
    left_we_gate_chk: assert property (@(posedge clk) disable iff (rst)
        (master_mode && l_we) |-> (l_en && l_wr && l_busy_n_out));

    // R7
    right_we_gate_chk: assert property (@(posedge clk) disable iff (rst)
        (master_mode && r_we) |-> (r_en && r_wr && r_busy_n_out));

    // R8
    follower_release_chk: assert property (@(posedge clk) disable iff (rst)
        !master_mode |-> (!l_busy_oe && !r_busy_oe && l_busy_n_out && r_busy_n_out));

    // R9
    driver_enable_chk: assert property (@(posedge clk) disable iff (rst)
        master_mode |-> (l_busy_oe && r_busy_oe));
endmodule

bind dp_collision_arbiter dp_collision_arbiter_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .master_mode  (master_mode),
    .l_en         (l_en),
    .l_addr       (l_addr),
    .l_wr         (l_wr),
    .l_busy_n_out (l_busy_n_out),
    .l_busy_oe    (l_busy_oe),
    .l_we         (l_we),
    .r_en         (r_en),
    .r_addr       (r_addr),
    .r_wr         (r_wr),
    .r_busy_n_out (r_busy_n_out),
    .r_busy_oe    (r_busy_oe),
    .r_we         (r_we)
);

// File: tb/dp_collision_arbiter_tb.sv
module dp_collision_arbiter_tb;
    localparam int  ADDR_W = 13;
    localparam time PERIOD = 10;

    logic              clk = 0;
    logic              rst;
    logic              master_mode;
    logic              l_en, l_wr, l_busy_n_in;
    logic [ADDR_W-1:0] l_addr;
    logic              r_en, r_wr, r_busy_n_in;
    logic [ADDR_W-1:0] r_addr;
    logic              l_busy_n_out, l_busy_oe, l_we;
    logic              r_busy_n_out, r_busy_oe, r_we;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    logic [5:0] exp_q [$];
    string      tag_q [$];

    // Bench model state: 0 none, 1 left, 2 right
    int              m_own;
    logic [ADDR_W:0] m_prev_l, m_prev_r;

    always #(PERIOD/2) clk = ~clk;

    dp_collision_arbiter #(.ADDR_W(ADDR_W)) u_dut (
        .clk(clk), .rst(rst), .master_mode(master_mode),
        .l_en(l_en), .l_addr(l_addr), .l_wr(l_wr), .l_busy_n_in(l_busy_n_in),
        .l_busy_n_out(l_busy_n_out), .l_busy_oe(l_busy_oe), .l_we(l_we),
        .r_en(r_en), .r_addr(r_addr), .r_wr(r_wr), .r_busy_n_in(r_busy_n_in),
        .r_busy_n_out(r_busy_n_out), .r_busy_oe(r_busy_oe), .r_we(r_we)
    );

    // Driver: applies one cycle of stimulus and queues the expected pins.
    task automatic step(input logic m,
                        input logic le, input logic [ADDR_W-1:0] la, input logic lw,
                        input logic re, input logic [ADDR_W-1:0] ra, input logic rw,
                        input logic bl, input logic br, input string tag);
        logic [ADDR_W:0] cl, cr;
        logic            mvl, mvr, col, lose_l, lose_r;
        int              g;
        logic [5:0]      e;
        @(negedge clk);
        master_mode = m;
        l_en = le; l_addr = la; l_wr = lw; l_busy_n_in = bl;
        r_en = re; r_addr = ra; r_wr = rw; r_busy_n_in = br;
        cl  = le ? {1'b1, la} : '0;
        cr  = re ? {1'b1, ra} : '0;
        mvl = (cl != m_prev_l);
        mvr = (cr != m_prev_r);
        col = m && le && re && (la == ra);
        g = 0;
        if (col) begin
            if (m_own == 1 && !mvl)      g = 1;
            else if (m_own == 2 && !mvr) g = 2;
            else if (mvr && !mvl)        g = 1;
            else if (mvl && !mvr)        g = 2;
            else                         g = 1;
        end
        lose_l = (g == 2);
        lose_r = (g == 1);
        if (m) begin
            e[5] = ~lose_l; e[4] = ~lose_r; e[3] = 1'b1; e[2] = 1'b1;
            e[1] = le & lw & ~lose_l;
            e[0] = re & rw & ~lose_r;
        end else begin
            e[5] = 1'b1; e[4] = 1'b1; e[3] = 1'b0; e[2] = 1'b0;
            e[1] = le & lw & bl;
            e[0] = re & rw & br;
        end
        exp_q.push_back(e);
        tag_q.push_back(tag);
        m_prev_l = cl;
        m_prev_r = cr;
        m_own    = g;
    endtask

    // Monitor: compares the pins a quarter period after each drive edge.
    initial begin
        forever begin
            @(negedge clk);
            #(PERIOD/4);
            if (exp_q.size() > 0) begin
                logic [5:0] act, e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                act = {l_busy_n_out, r_busy_n_out, l_busy_oe, r_busy_oe, l_we, r_we};
                checks++;
                if (act !== e) begin
                    fails++;
                    $display("FAIL %s: {lbusy,rbusy,loe,roe,lwe,rwe} actual=%b expected=%b", t, act, e);
                end
            end
        end
    end

    initial begin
        #(PERIOD*20000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

    initial begin
        rst = 1; master_mode = 1;
        l_en = 0; l_addr = '0; l_wr = 0; l_busy_n_in = 1;
        r_en = 0; r_addr = '0; r_wr = 0; r_busy_n_in = 1;
        m_own = 0; m_prev_l = '0; m_prev_r = '0;
        repeat (3) @(negedge clk);
        rst = 0;
        // R10 reset state, ports idle
        step(1, 0, 13'd0, 0, 0, 13'd0, 0, 1, 1, "R10 reset idle");
        // R1 distinct addresses
        step(1, 1, 13'd5, 1, 1, 13'd6, 1, 1, 1, "R1 distinct addresses");
        // R3 right moves onto parked left
        step(1, 1, 13'd5, 1, 1, 13'd5, 1, 1, 1, "R3 right arrives late");
        // R5 hold
        step(1, 1, 13'd5, 1, 1, 13'd5, 1, 1, 1, "R5 grant held");
        // R2 write flags toggled during collision
        step(1, 1, 13'd5, 0, 1, 13'd5, 0, 1, 1, "R2 reads same decision");
        step(1, 1, 13'd5, 1, 1, 13'd5, 0, 1, 1, "R2 mixed flags");
        // R5 winner releases
        step(1, 0, 13'd5, 1, 1, 13'd5, 1, 1, 1, "R5 winner releases");
        // R3 left re-enters late, right owns
        step(1, 1, 13'd5, 1, 1, 13'd5, 1, 1, 1, "R3 left arrives late");
        step(1, 1, 13'd5, 1, 1, 13'd5, 1, 1, 1, "R5 right holds");
        // R4 simultaneous move
        step(1, 1, 13'd9, 1, 1, 13'd9, 1, 1, 1, "R4 simultaneous tie");
        step(1, 0, 13'd0, 0, 0, 13'd0, 0, 1, 1, "R1 both idle");
        step(1, 1, 13'h1FFF, 1, 1, 13'h1FFF, 1, 1, 1, "R4 tie at top address");
        // R7 busy inputs ignored when arbitrating
        step(1, 1, 13'd2, 1, 1, 13'd3, 1, 0, 0, "R7 busy inputs ignored");
        // R8 follower mode
        step(0, 1, 13'd4, 1, 1, 13'd4, 1, 0, 1, "R8 follower left inhibited");
        step(0, 1, 13'd4, 1, 1, 13'd4, 1, 1, 0, "R8 follower right inhibited");
        step(0, 1, 13'd4, 1, 1, 13'd4, 1, 1, 1, "R8 follower no inhibit");
        // R9 back to arbitrating with unchanged requests: tie, left wins
        step(1, 1, 13'd4, 1, 1, 13'd4, 1, 1, 1, "R9 R4 mode return tie");
        step(1, 1, 13'd4, 1, 1, 13'd7, 1, 1, 1, "R6 R1 right leaves");
        repeat (3) @(negedge clk);
        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule